// File: doc/BRIEF.md
# Chained Buffer DMA Channel

This block is one DMA channel. It moves 32-bit words between a streaming device port and a simple request/acknowledge memory bus. Software sets it up through a small register file. One register is the control/status word, whose write bits act as one-shot commands and whose upper bits read back the channel state. The others are address registers: a current pointer and its end pointer, plus the base and end of a follow-on buffer. The channel advances the current pointer one word at a time. When the pointer meets its end pointer, the current buffer is finished.

At that point the channel can load the follow-on buffer and carry on, or it can stop. The choice depends on a single-update flag. A completion flag and a bus-exception flag drive one interrupt line. A set of saved pointer copies is kept up to date by software writes and by each buffer swap. An initialise command copies the saved set back into the live pointers, so a channel that stopped on a bus error can be started again from the beginning of its buffer. A completion that arrives while an earlier one is still unacknowledged is recorded as an overrun-pending flag. The clear-complete command removes that flag first.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset, every status bit reads 0, all eight pointer registers read 0, `irq` is low and `mem_req` is low.
- R2: The registers are selected by index: 0 control/status, 1 current, 2 end, 3 follow-on base, 4 follow-on end, and 5 to 8 the saved copies in the same order. A write to a pointer clears its low ALIGN_BITS bits (default 4, so addresses are 16-byte aligned). A write to a live pointer (index 1 to 4) stores the same value in its saved copy.
- R3: The control/status write bits are: 16 sets enable, 17 sets single-update, 19 clears complete, 20 is the reset command and 21 is the initialise command. Every control/status write also stores bit 18 as the direction. The readback bits are: 18 direction, 24 enable, 25 single-update, 26 overrun pending, 27 complete and 28 bus exception.
- R4: With direction 1, each word the device offers is written to memory at the current pointer, and the current pointer then advances by 4.
- R5: `mem_req` is raised only while enable is set and the current pointer differs from the end pointer.
- R6: When the last word of a buffer is moved with single-update set, complete is set, enable is cleared, and the current pointer is left equal to the end pointer.
- R7: When the last word of a buffer is moved with single-update clear, complete is set, the current and end pointers (and their saved copies) take the follow-on base and end, and transfers continue.
- R8: With direction 0, the word read from memory at the current pointer is presented on the device output in the cycle it is acknowledged.
- R9: A buffer end while complete is already set raises overrun pending. Clear-complete then clears overrun pending only. Complete is cleared by a clear-complete issued while overrun pending is 0.
- R10: The reset command clears enable, single-update, complete, overrun pending and bus exception. Set-enable and set-single-update in the same write take effect after it.
- R11: An error response sets bus exception and clears enable. It does not advance the current pointer and writes no data, and no request follows it.
- R12: The initialise command copies the four saved pointers into the live pointers.
- R13: `irq` is high exactly while complete or bus exception is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| dev_in_valid | input | 1 | Device offers a word (direction 1) |
| dev_in_data | input | DATA_W | Word from the device |
| dev_in_ready | output | 1 | Device word taken |
| dev_out_valid | output | 1 | Word for the device is present (direction 0) |
| dev_out_data | output | DATA_W | Word for the device |
| dev_out_ready | input | 1 | Device can take a word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_err | input | 1 | Access completed with an error |
| irq | output | 1 | Completion or bus-exception interrupt |

## Verification
The bench builds the channel with its default parameters: ALIGN_BITS of 4 and DATA_W of 32. With these values the 16-byte masking of pointer writes can be seen directly, and buffers of four and eight words fit inside a small memory model. That is short enough to run two buffer swaps back to back and so produce an overrun. An error response placed in the middle of a buffer exercises the stop path and the restart from the saved pointers.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int PTR_W = 32;

  // command bits in a control/status write
  localparam int B_SET_EN  = 16;
  localparam int B_SET_SUP = 17;
  localparam int B_DIR     = 18;
  localparam int B_CLR_CMP = 19;
  localparam int B_RESET   = 20;
  localparam int B_INIT    = 21;

  // status bits in a control/status read
  localparam int S_EN   = 24;
  localparam int S_SUP  = 25;
  localparam int S_PEND = 26;
  localparam int S_CMP  = 27;
  localparam int S_BEX  = 28;

  typedef enum logic [3:0] {
    RI_CSR      = 4'd0,
    RI_NEXT     = 4'd1,
    RI_LIMIT    = 4'd2,
    RI_START    = 4'd3,
    RI_STOP     = 4'd4,
    RI_SV_NEXT  = 4'd5,
    RI_SV_LIMIT = 4'd6,
    RI_SV_START = 4'd7,
    RI_SV_STOP  = 4'd8
  } reg_idx_e;

  typedef struct packed {
    logic [PTR_W-1:0] nxt;
    logic [PTR_W-1:0] lim;
    logic [PTR_W-1:0] srt;
    logic [PTR_W-1:0] stp;
  } ptr_set_t;

  typedef struct packed {
    logic init;
    logic rst;
    logic clr_cmp;
    logic dir;
    logic set_sup;
    logic set_en;
  } csr_cmd_t;

  // clear the low alignment bits of an address
  function automatic logic [PTR_W-1:0] ptr_align(input logic [PTR_W-1:0] p,
                                                 input int unsigned lsb);
    logic [PTR_W-1:0] m;
    m = '1;
    m = m << lsb;
    return p & m;
  endfunction

  // address of the following word
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return p + PTR_W'(4);
  endfunction
endpackage

// File: rtl/dma_chain_ptrs.sv
module dma_chain_ptrs
  import dma_chain_pkg::*;
#(
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [PTR_W-1:0] wdata,
  input  logic             step_ev,
  input  logic             chain_ev,
  input  logic             init_cmd,
  output ptr_set_t         live,
  output ptr_set_t         saved
);
  localparam int NSLOT = 4;

  logic [PTR_W-1:0] live_q [NSLOT];
  logic [PTR_W-1:0] sv_q   [NSLOT];
  logic [PTR_W-1:0] wr_val;

  assign wr_val = ptr_align(wdata, ALIGN_BITS);

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam bit IS_BUF0 = (k < 2);
    localparam bit IS_NEXT = (k == 0);
    logic [PTR_W-1:0] chain_val;
    logic             live_hit;
    logic             sv_hit;

    if (IS_BUF0) begin : g_src
      assign chain_val = live_q[k+2];
    end else begin : g_keep
      assign chain_val = live_q[k];
    end

    assign live_hit = wr_en && (wr_idx == 4'(k + 1));
    assign sv_hit   = wr_en && (wr_idx == 4'(k + 1 + NSLOT));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[k] <= '0;
        sv_q[k]   <= '0;
      end else if (live_hit) begin
        live_q[k] <= wr_val;
        sv_q[k]   <= wr_val;
      end else if (sv_hit) begin
        sv_q[k] <= wr_val;
      end else if (init_cmd) begin
        live_q[k] <= sv_q[k];
      end else if (chain_ev && IS_BUF0) begin
        live_q[k] <= chain_val;
        sv_q[k]   <= chain_val;
      end else if (step_ev && IS_NEXT) begin
        live_q[k] <= ptr_step(live_q[k]);
      end
    end
  end

  assign live.nxt  = live_q[0];
  assign live.lim  = live_q[1];
  assign live.srt  = live_q[2];
  assign live.stp  = live_q[3];
  assign saved.nxt = sv_q[0];
  assign saved.lim = sv_q[1];
  assign saved.srt = sv_q[2];
  assign saved.stp = sv_q[3];
endmodule

// File: rtl/dma_chain_csr.sv
module dma_chain_csr
  import dma_chain_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     csr_wr,
  input  csr_cmd_t cmd,
  input  logic     word_done,
  input  logic     word_err,
  input  logic     last_word,
  output logic     en,
  output logic     sup,
  output logic     dir,
  output logic     cmp,
  output logic     pend,
  output logic     bex,
  output logic     end_ev,
  output logic     chain_ev,
  output logic     init_cmd
);
  assign end_ev   = word_done && last_word;
  assign chain_ev = end_ev && !sup;
  assign init_cmd = csr_wr && cmd.init;

  // software commands first, hardware events after them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      sup  <= 1'b0;
      dir  <= 1'b0;
      cmp  <= 1'b0;
      pend <= 1'b0;
      bex  <= 1'b0;
    end else begin
      if (csr_wr) begin
        dir <= cmd.dir;
        if (cmd.clr_cmp) begin
          if (pend) pend <= 1'b0;
          else      cmp  <= 1'b0;
        end
        if (cmd.rst) begin
          en   <= 1'b0;
          sup  <= 1'b0;
          cmp  <= 1'b0;
          pend <= 1'b0;
          bex  <= 1'b0;
        end
        if (cmd.set_en)  en  <= 1'b1;
        if (cmd.set_sup) sup <= 1'b1;
      end
      if (end_ev) begin
        cmp <= 1'b1;
        if (cmp) pend <= 1'b1;
        if (sup) en   <= 1'b0;
      end
      if (word_err) begin
        en  <= 1'b0;
        bex <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chain_port.sv
module dma_chain_port
  import dma_chain_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              active,
  input  logic              dir,
  input  logic [PTR_W-1:0]  nxt,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              word_done,
  output logic              word_err
);
  logic side_ok;

  // direction 1: device to memory; direction 0: memory to device
  assign side_ok   = dir ? dev_in_valid : dev_out_ready;
  assign mem_req   = active && side_ok;
  assign mem_we    = dir;
  assign mem_addr  = nxt;
  assign mem_wdata = dev_in_data;

  assign word_done = mem_req && mem_ack && !mem_err;
  assign word_err  = mem_req && mem_ack && mem_err;

  assign dev_in_ready  = dir && word_done;
  assign dev_out_valid = !dir && word_done;
  assign dev_out_data  = mem_rdata;
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_chain_pkg::*;
#(
  parameter int unsigned ALIGN_BITS = 4,
  parameter int          DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_idx,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              irq
);
  ptr_set_t live, saved;
  csr_cmd_t cmd;
  logic csr_wr, en, sup, dir, cmp, pend, bex;
  logic end_ev, chain_ev, init_cmd;
  logic word_done, word_err, last_word, active;
  logic [31:0] csr_rd;

  assign csr_wr      = reg_wr && (reg_idx == RI_CSR);
  assign cmd.init    = reg_wdata[B_INIT];
  assign cmd.rst     = reg_wdata[B_RESET];
  assign cmd.clr_cmp = reg_wdata[B_CLR_CMP];
  assign cmd.dir     = reg_wdata[B_DIR];
  assign cmd.set_sup = reg_wdata[B_SET_SUP];
  assign cmd.set_en  = reg_wdata[B_SET_EN];

  assign active    = en && (live.nxt != live.lim);
  assign last_word = (ptr_step(live.nxt) == live.lim);

  dma_chain_csr u_csr (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .cmd(cmd),
    .word_done(word_done), .word_err(word_err), .last_word(last_word),
    .en(en), .sup(sup), .dir(dir), .cmp(cmp), .pend(pend), .bex(bex),
    .end_ev(end_ev), .chain_ev(chain_ev), .init_cmd(init_cmd)
  );

  dma_chain_ptrs #(.ALIGN_BITS(ALIGN_BITS)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(reg_idx),
    .wdata(reg_wdata), .step_ev(word_done), .chain_ev(chain_ev),
    .init_cmd(init_cmd), .live(live), .saved(saved)
  );

  dma_chain_port #(.DATA_W(DATA_W)) u_port (
    .active(active), .dir(dir), .nxt(live.nxt),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .word_done(word_done), .word_err(word_err)
  );

  always_comb begin
    csr_rd         = '0;
    csr_rd[B_DIR]  = dir;
    csr_rd[S_EN]   = en;
    csr_rd[S_SUP]  = sup;
    csr_rd[S_PEND] = pend;
    csr_rd[S_CMP]  = cmp;
    csr_rd[S_BEX]  = bex;
  end

  always_comb begin
    case (reg_idx)
      RI_CSR:      reg_rdata = csr_rd;
      RI_NEXT:     reg_rdata = live.nxt;
      RI_LIMIT:    reg_rdata = live.lim;
      RI_START:    reg_rdata = live.srt;
      RI_STOP:     reg_rdata = live.stp;
      RI_SV_NEXT:  reg_rdata = saved.nxt;
      RI_SV_LIMIT: reg_rdata = saved.lim;
      RI_SV_START: reg_rdata = saved.srt;
      RI_SV_STOP:  reg_rdata = saved.stp;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq = cmp || bex;
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        en,
  input logic        sup,
  input logic        cmp,
  input logic        pend,
  input logic        bex,
  input logic        word_done,
  input logic        word_err,
  input logic        last_word,
  input logic        end_ev,
  input logic        chain_ev,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic [31:0] nxt,
  input logic [31:0] lim,
  input logic [31:0] srt,
  input logic [31:0] stp
);
  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (en && nxt != lim)); // R5

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

  AST_STEP_BY_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !last_word && !reg_wr) |=> (nxt == $past(nxt) + 32'd4)); // R4

  AST_SINGLE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ev && sup && !reg_wr) |=> (!en && cmp)); // R6

  AST_CHAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_ev && !reg_wr) |=> (nxt == $past(srt) && lim == $past(stp) && cmp)); // R7

  AST_PEND_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> cmp); // R9

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_err && !reg_wr) |=> (!en && bex && nxt == $past(nxt))); // R11
endmodule

bind dma_chain_chan dma_chain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
  .en(en), .sup(sup), .cmp(cmp), .pend(pend), .bex(bex),
  .word_done(word_done), .word_err(word_err), .last_word(last_word),
  .end_ev(end_ev), .chain_ev(chain_ev),
  .mem_req(mem_req), .mem_addr(mem_addr),
  .nxt(live.nxt), .lim(live.lim), .srt(live.srt), .stp(live.stp)
);

// File: tb/dma_chain_chan_tb.sv
`timescale 1ns/1ps
module dma_chain_chan_tb;
  localparam logic [31:0] C_SET_EN  = 32'h0001_0000;
  localparam logic [31:0] C_SET_SUP = 32'h0002_0000;
  localparam logic [31:0] C_DIR     = 32'h0004_0000;
  localparam logic [31:0] C_CLR     = 32'h0008_0000;
  localparam logic [31:0] C_RST     = 32'h0010_0000;
  localparam logic [31:0] C_INIT    = 32'h0020_0000;
  localparam logic [31:0] M_EN  = 32'h0100_0000;
  localparam logic [31:0] M_SUP = 32'h0200_0000;
  localparam logic [31:0] M_PND = 32'h0400_0000;
  localparam logic [31:0] M_CMP = 32'h0800_0000;
  localparam logic [31:0] M_BEX = 32'h1000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_idx = 4'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic dev_in_valid = 1'b0;
  logic [31:0] dev_in_data;
  logic dev_in_ready;
  logic dev_out_valid;
  logic [31:0] dev_out_data;
  logic dev_out_ready = 1'b0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_ack = 1'b1;
  logic mem_err;
  logic err_on = 1'b0;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] wr_mem [0:511];
  int wr_cnt = 0;
  int src_cnt = 0;
  logic [31:0] sink_buf [0:31];
  int sink_n = 0;

  always #4 clk = ~clk;

  dma_chain_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_ready(dev_in_ready), .dev_out_valid(dev_out_valid),
    .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq)
  );

  // memory and device models
  assign mem_rdata   = {16'hC0DE, mem_addr[15:0]};
  assign mem_err     = err_on && (mem_addr == 32'h0000_0408);
  assign dev_in_data = 32'hA000_0000 + 32'(src_cnt);

  always @(posedge clk) begin
    if (mem_req && mem_ack && !mem_err && mem_we) begin
      wr_mem[mem_addr[10:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (dev_in_valid && dev_in_ready) src_cnt <= src_cnt + 1;
    if (dev_out_valid && dev_out_ready && sink_n < 32) begin
      sink_buf[sink_n] <= dev_out_data;
      sink_n <= sink_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] idx, output logic [31:0] d);
    reg_idx = idx;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    reg_read(4'd0, v);
    check(v == 32'h0, "R1 csr after reset", v, 32'h0);
    for (int k = 1; k <= 8; k++) begin
      reg_read(4'(k), v);
      check(v == 32'h0, "R1 pointer after reset", v, 32'h0);
    end
    check(irq == 1'b0 && mem_req == 1'b0, "R1 irq/mem_req low", {30'h0, irq, mem_req}, 32'h0);
  endtask

  task automatic t_align();
    logic [31:0] v;
    reg_write(4'd1, 32'h0000_010C);
    reg_read(4'd1, v);
    check(v == 32'h100, "R2 current pointer masked", v, 32'h100);
    reg_read(4'd5, v);
    check(v == 32'h100, "R2 saved copy follows write", v, 32'h100);
    reg_write(4'd8, 32'h0000_0777);
    reg_read(4'd8, v);
    check(v == 32'h770, "R2 saved end written directly", v, 32'h770);
    reg_read(4'd4, v);
    check(v == 32'h0, "R2 live end untouched", v, 32'h0);
  endtask

  task automatic t_single_write();
    logic [31:0] v;
    int s0, w0;
    reg_write(4'd1, 32'h100);
    reg_write(4'd2, 32'h120);
    @(negedge clk);
    s0 = src_cnt; w0 = wr_cnt;
    dev_in_valid = 1'b1;
    reg_write(4'd0, C_SET_EN | C_SET_SUP | C_DIR);
    wait_irq();
    repeat (3) @(negedge clk);
    check(mem_req == 1'b0, "R5 no request after halt", {31'h0, mem_req}, 32'h0);
    dev_in_valid = 1'b0;
    check(wr_cnt - w0 == 8, "R4 word count", 32'(wr_cnt - w0), 32'd8);
    for (int i = 0; i < 8; i++)
      check(wr_mem[9'h40 + 9'(i)] == 32'hA000_0000 + 32'(s0 + i), "R4 written word",
            wr_mem[9'h40 + 9'(i)], 32'hA000_0000 + 32'(s0 + i));
    reg_read(4'd0, v);
    check(v == (M_CMP | M_SUP | C_DIR), "R6 R3 status after single buffer", v,
          M_CMP | M_SUP | C_DIR);
    reg_read(4'd1, v);
    check(v == 32'h120, "R6 current stays at end", v, 32'h120);
    check(irq == 1'b1, "R13 irq on complete", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_chain_read();
    logic [31:0] v;
    reg_write(4'd0, C_RST);
    check(irq == 1'b0, "R10 R13 reset command drops irq", {31'h0, irq}, 32'h0);
    reg_write(4'd1, 32'h200);
    reg_write(4'd2, 32'h210);
    reg_write(4'd3, 32'h300);
    reg_write(4'd4, 32'h320);
    @(negedge clk);
    sink_n = 0;
    dev_out_ready = 1'b1;
    reg_write(4'd0, C_SET_EN);
    for (int i = 0; i < 200 && sink_n < 12; i++) @(negedge clk);
    dev_out_ready = 1'b0;
    check(sink_n == 12, "R8 words delivered", 32'(sink_n), 32'd12);
    for (int i = 0; i < 12; i++) begin
      logic [31:0] e;
      e = (i < 4) ? {16'hC0DE, 16'h0200 + 16'(4 * i)} : {16'hC0DE, 16'h0300 + 16'(4 * (i - 4))};
      check(sink_buf[i] == e, "R8 R7 read word order", sink_buf[i], e);
    end
    reg_read(4'd0, v);
    check(v == (M_EN | M_CMP | M_PND), "R7 R9 running with overrun", v, M_EN | M_CMP | M_PND);
    reg_read(4'd1, v);
    check(v == 32'h300, "R7 current reloaded", v, 32'h300);
    reg_read(4'd2, v);
    check(v == 32'h320, "R7 end reloaded", v, 32'h320);
    reg_read(4'd5, v);
    check(v == 32'h300, "R7 saved current follows swap", v, 32'h300);
    reg_write(4'd0, C_CLR);
    reg_read(4'd0, v);
    check(v == (M_EN | M_CMP), "R9 first clear drops pending only", v, M_EN | M_CMP);
    reg_write(4'd0, C_CLR);
    reg_read(4'd0, v);
    check(v == M_EN, "R9 second clear drops complete", v, M_EN);
    check(irq == 1'b0, "R13 irq low after clears", {31'h0, irq}, 32'h0);
    reg_write(4'd0, C_SET_SUP);
    reg_write(4'd0, C_RST | C_SET_SUP);
    reg_read(4'd0, v);
    check(v == M_SUP, "R10 reset then set in one write", v, M_SUP);
    reg_write(4'd0, C_RST);
    reg_read(4'd0, v);
    check(v == 32'h0, "R10 reset clears all", v, 32'h0);
  endtask

  task automatic t_bus_err();
    logic [31:0] v;
    int w0, s0;
    reg_write(4'd1, 32'h400);
    reg_write(4'd2, 32'h420);
    @(negedge clk);
    err_on = 1'b1;
    w0 = wr_cnt;
    dev_in_valid = 1'b1;
    reg_write(4'd0, C_SET_EN | C_SET_SUP | C_DIR);
    wait_irq();
    repeat (2) @(negedge clk);
    check(mem_req == 1'b0, "R11 no request after error", {31'h0, mem_req}, 32'h0);
    check(wr_cnt - w0 == 2, "R11 words before error", 32'(wr_cnt - w0), 32'd2);
    reg_read(4'd0, v);
    check(v == (M_BEX | M_SUP | C_DIR), "R11 status after error", v, M_BEX | M_SUP | C_DIR);
    reg_read(4'd1, v);
    check(v == 32'h408, "R11 current not advanced", v, 32'h408);
    check(irq == 1'b1, "R13 irq on bus exception", {31'h0, irq}, 32'h1);
    err_on = 1'b0;
    reg_write(4'd0, C_RST | C_INIT);
    reg_read(4'd1, v);
    check(v == 32'h400, "R12 current restored", v, 32'h400);
    reg_read(4'd2, v);
    check(v == 32'h420, "R12 end restored", v, 32'h420);
    reg_read(4'd0, v);
    check(v == 32'h0, "R10 bus exception cleared", v, 32'h0);
    @(negedge clk);
    s0 = src_cnt; w0 = wr_cnt;
    reg_write(4'd0, C_SET_EN | C_SET_SUP | C_DIR);
    wait_irq();
    repeat (2) @(negedge clk);
    dev_in_valid = 1'b0;
    check(wr_cnt - w0 == 8, "R12 restart moves whole buffer", 32'(wr_cnt - w0), 32'd8);
    check(wr_mem[9'h100] == 32'hA000_0000 + 32'(s0), "R12 restart first word",
          wr_mem[9'h100], 32'hA000_0000 + 32'(s0));
    reg_read(4'd0, v);
    check(v == (M_CMP | M_SUP | C_DIR), "R6 restart completes", v, M_CMP | M_SUP | C_DIR);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_align();
    t_single_write();
    t_chain_read();
    t_bus_err();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired (R1 to R13 incomplete)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule